// File: doc/BRIEF.md
# Boundary-Scan Pin Cell Chain

This block strings together one scan cell per bidirectional pin. A tester uses it to watch or override the signals between core logic and pads. Each cell has three capture stages and three update stages. The capture stages take the core's output value, the core's active-low output enable and the value arriving from the pad. The update stages hold the value to drive, the enable to drive with, and the value to hand to the core while test mode is on.

The capture stages of all cells form a single shift register that runs from `scan_in` to `scan_out`. A TAP controller supplies three synchronous strobes on `clk`: capture, shift and update. An instruction decoder supplies `test_mode`. When `test_mode` is low, every cell is a plain wire between core and pad. When it is high, the pads and the core input see only the update stages. Those stages change on the update strobe and at no other time, so values moving through the chain never reach the pins.

Top module: `bscan_chain`

## Requirements
- R1: After reset the whole capture chain is 0, so `scan_out` is 0. Every enable update stage holds 1 (pin released), and every output and input update stage holds 0.
- R2: With `test_mode` = 0, `pin_out` equals `core_out`, `pin_oe_n` equals `core_oe_n` and `core_in` equals `pin_in`, bit for bit, with no added cycle.
- R3: On a `clk` edge with `capture_en` = 1, chain position 3i loads `core_out[i]`, position 3i+1 loads `core_oe_n[i]` and position 3i+2 loads `pin_in[i]`. `scan_out` always shows position 3N-1, which is the input stage of cell N-1.
- R4: On a `clk` edge with `shift_en` = 1 and `capture_en` = 0, each position takes the value of the one below it and position 0 takes `scan_in`. Inside a cell the serial order is output, then enable, then input. After a capture, 3N shifts therefore present, in order: cell N-1 input, enable, output, then cell N-2, and so on down to cell 0.
- R5: The update stages, and so the pins in test mode, keep their value on every edge without `update_en`. This holds while the chain shifts or captures.
- R6: On a `clk` edge with `update_en` = 1, every update stage copies the chain position it belongs to. With `test_mode` = 1, `pin_out[i]` is output update i, `pin_oe_n[i]` is enable update i (0 drives the pin) and `core_in[i]` is input update i. `core_out` and `core_oe_n` have no effect on the pins.
- R7: When `capture_en` and `shift_en` are both 1 on the same edge, the capture takes place and the shift does not.
- R8: A bit applied at `scan_in` appears at `scan_out` after exactly 3N shift edges. A value preloaded into the chain therefore flushes out in the order given in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock; all stages change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_in | input | 1 | Serial data entering cell 0 output stage |
| scan_out | output | 1 | Serial data from cell N-1 input stage |
| shift_en | input | 1 | Shift strobe from the TAP controller |
| capture_en | input | 1 | Parallel capture strobe from the TAP controller |
| update_en | input | 1 | Update strobe from the TAP controller |
| test_mode | input | 1 | 1 selects update stages for drive, 0 is transparent |
| core_out | input | N | Output values from core logic |
| core_oe_n | input | N | Active-low output enables from core logic |
| pin_in | input | N | Values received from the pads |
| pin_out | output | N | Values sent to the pads |
| pin_oe_n | output | N | Active-low enables sent to the pads |
| core_in | output | N | Values delivered to core logic |

## Verification
A stage that is wrong, dropped or out of order in the chain shows up at `scan_out`. It appears during the 3N-bit stream that follows a capture, at the exact bit position of that stage. It also appears when a preload is flushed out. An update stage that takes a wrong value, or one that moves during shifting, shows on `pin_out`, `pin_oe_n` or `core_in` in the first cycle after the update edge, or during the shift when it should have held. A fault in transparency or in mode selection shows on the pins in the same cycle that `test_mode` or the core inputs change.

// File: rtl/bscan_chain.sv
module bscan_chain #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         scan_in,
  output logic         scan_out,
  input  logic         shift_en,
  input  logic         capture_en,
  input  logic         update_en,
  input  logic         test_mode,
  input  logic [N-1:0] core_out,
  input  logic [N-1:0] core_oe_n,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] pin_out,
  output logic [N-1:0] pin_oe_n,
  output logic [N-1:0] core_in
);
  localparam int W = 3 * N;

  function automatic logic [W-1:0] oe_ones();
    logic [W-1:0] m;
    m = '0;
    for (int i = 0; i < N; i++) m[3*i+1] = 1'b1;
    return m;
  endfunction

  localparam logic [W-1:0] UPD_RST = oe_ones();

  logic [W-1:0] sr;
  logic [W-1:0] upd;
  logic [W-1:0] cap_vec;

  for (genvar i = 0; i < N; i++) begin : g_cell
    assign cap_vec[3*i]   = core_out[i];
    assign cap_vec[3*i+1] = core_oe_n[i];
    assign cap_vec[3*i+2] = pin_in[i];
    assign pin_out[i]  = test_mode ? upd[3*i]   : core_out[i];
    assign pin_oe_n[i] = test_mode ? upd[3*i+1] : core_oe_n[i];
    assign core_in[i]  = test_mode ? upd[3*i+2] : pin_in[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sr <= '0;
    else if (capture_en) sr <= cap_vec;
    else if (shift_en)   sr <= {sr[W-2:0], scan_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         upd <= UPD_RST;
    else if (update_en) upd <= sr;
  end

  assign scan_out = sr[W-1];
endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
  parameter int N = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           scan_in,
  input logic           scan_out,
  input logic           shift_en,
  input logic           capture_en,
  input logic           update_en,
  input logic           test_mode,
  input logic [N-1:0]   core_out,
  input logic [N-1:0]   core_oe_n,
  input logic [N-1:0]   pin_in,
  input logic [N-1:0]   pin_out,
  input logic [N-1:0]   pin_oe_n,
  input logic [N-1:0]   core_in,
  input logic [3*N-1:0] sr,
  input logic [3*N-1:0] upd
);
  localparam int W = 3 * N;

  assert_transparent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |-> (pin_out == core_out && pin_oe_n == core_oe_n && core_in == pin_in));

  assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    capture_en |=> scan_out == $past(pin_in[N-1]));

  assert_shift_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !capture_en) |=> (sr[0] == $past(scan_in) && scan_out == $past(sr[W-2])));

  assert_chain_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !capture_en) |=> $stable(sr));

  assert_pins_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && !update_en) |=>
      (!test_mode || ($stable(pin_out) && $stable(pin_oe_n) && $stable(core_in))));

  assert_update_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    update_en |=> upd == $past(sr));
endmodule

bind bscan_chain bscan_chain_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .scan_in(scan_in), .scan_out(scan_out),
  .shift_en(shift_en), .capture_en(capture_en), .update_en(update_en),
  .test_mode(test_mode), .core_out(core_out), .core_oe_n(core_oe_n),
  .pin_in(pin_in), .pin_out(pin_out), .pin_oe_n(pin_oe_n), .core_in(core_in),
  .sr(sr), .upd(upd)
);

// File: tb/tb_bscan_chain.sv
`timescale 1ns/1ps
module tb_bscan_chain;
  localparam int N = 4;
  localparam int W = 3 * N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scan_in = 1'b0, shift_en = 1'b0, capture_en = 1'b0, update_en = 1'b0, test_mode = 1'b0;
  logic [N-1:0] core_out = '0, core_oe_n = '0, pin_in = '0;
  logic scan_out;
  logic [N-1:0] pin_out, pin_oe_n, core_in;

  int vectors = 0, miscompares = 0;
  logic exp_q[$];
  string cur_tag = "R4";
  bit finished = 0;

  always #10 clk = ~clk;

  bscan_chain #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n), .scan_in(scan_in), .scan_out(scan_out),
    .shift_en(shift_en), .capture_en(capture_en), .update_en(update_en),
    .test_mode(test_mode), .core_out(core_out), .core_oe_n(core_oe_n),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe_n(pin_oe_n), .core_in(core_in)
  );

  function automatic logic [W-1:0] pack(logic [N-1:0] o, logic [N-1:0] e, logic [N-1:0] p);
    logic [W-1:0] v;
    for (int i = 0; i < N; i++) begin
      v[3*i] = o[i]; v[3*i+1] = e[i]; v[3*i+2] = p[i];
    end
    return v;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  always @(negedge clk) begin
    if (rst_n && shift_en && !capture_en && exp_q.size() > 0) begin
      logic e;
      e = exp_q.pop_front();
      check(cur_tag, {31'b0, scan_out}, {31'b0, e});
    end
  end

  task automatic shift_vec(string tag, logic [W-1:0] vin, logic [W-1:0] vexp);
    cur_tag = tag;
    for (int k = 0; k < W; k++) begin
      scan_in = vin[W-1-k];
      exp_q.push_back(vexp[W-1-k]);
      shift_en = 1'b1;
      step();
    end
    shift_en = 1'b0;
    scan_in = 1'b0;
  endtask

  task automatic pins_are(string tag, logic [W-1:0] v);
    logic [N-1:0] o, e, p;
    for (int i = 0; i < N; i++) begin
      o[i] = v[3*i]; e[i] = v[3*i+1]; p[i] = v[3*i+2];
    end
    check(tag, pin_out, o);
    check(tag, pin_oe_n, e);
    check(tag, core_in, p);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      vectors++; miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] cap1, pre, cap2, pre2;
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    step();
    // R1: reset state
    check("R1", {31'b0, scan_out}, 32'd0);
    test_mode = 1'b1; #1;
    check("R1", pin_oe_n, {N{1'b1}});
    check("R1", pin_out, '0);
    check("R1", core_in, '0);
    // R2: transparency, two patterns
    test_mode = 1'b0;
    core_out = 4'hA; core_oe_n = 4'h5; pin_in = 4'h3; #1;
    pins_are("R2", pack(4'hA, 4'h5, 4'h3));
    core_out = 4'h6; core_oe_n = 4'hC; pin_in = 4'h9; #1;
    pins_are("R2", pack(4'h6, 4'hC, 4'h9));
    // R3: capture
    core_out = 4'b1010; core_oe_n = 4'b0110; pin_in = 4'b1101;
    cap1 = pack(core_out, core_oe_n, pin_in);
    step();
    capture_en = 1'b1; step(); capture_en = 1'b0;
    check("R3", {31'b0, scan_out}, {31'b0, pin_in[N-1]});
    // R4 stream of captured bits while preloading; R5 pins hold in test mode
    test_mode = 1'b1;
    pre = 12'b1001_0110_0011;
    shift_vec("R4", pre, cap1);
    pins_are("R5", {N{3'b010}});
    capture_en = 1'b1; step(); capture_en = 1'b0;
    pins_are("R5", {N{3'b010}});
    // R6: update drives pins
    update_en = 1'b1; step(); update_en = 1'b0;
    pins_are("R6", cap1);
    // restore preload and update
    shift_vec("R4", pre, cap1);
    update_en = 1'b1; step(); update_en = 1'b0;
    pins_are("R6", pre);
    core_out = ~core_out; core_oe_n = ~core_oe_n; pin_in = ~pin_in; #1;
    pins_are("R6", pre);
    // R7: capture beats shift
    core_out = 4'b0011; core_oe_n = 4'b1001; pin_in = 4'b0101;
    cap2 = pack(core_out, core_oe_n, pin_in);
    capture_en = 1'b1; shift_en = 1'b1; scan_in = 1'b1;
    step();
    capture_en = 1'b0; shift_en = 1'b0; scan_in = 1'b0;
    check("R7", {31'b0, scan_out}, {31'b0, cap2[W-1]});
    pre2 = 12'b0111_1000_1101;
    shift_vec("R7", pre2, cap2);
    pins_are("R5", pre);
    // R8: flush preload out after 3N shifts
    shift_vec("R8", '0, pre2);
    // R2 again after test mode
    test_mode = 1'b0; #1;
    pins_are("R2", cap2);
    step();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule